// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block computes where the program counter goes next for the non-delayed control-transfer instructions of a 32-bit core with 16-bit instruction words. Each request carries the instruction halfword, the address of that instruction, the four condition flags, the value of the register the instruction names, and the current return-pointer value. The block returns the next PC. It also returns a return-pointer write with its data, and a flag that tells the pipeline controller the transfer costs one extra cycle.

The block handles sixteen conditional relative branches, a call with an 11-bit relative offset, a call through a register, a jump through a register, and a return through the return pointer. Any other halfword simply advances the PC by two. Requests enter on a valid/ready channel and results leave on another. One output register sits between them. A new request is accepted whenever that register is empty or its content is being taken in the same cycle. While the consumer holds ready low, the held result stays unchanged and new requests are refused. The flags are only read, never produced.

Top module: `flow_redirect_unit`

## Requirements
- R1: `in_ready` is high exactly when no result is held or `out_ready` is high. An accepted request appears on the outputs with `out_valid` in the next cycle. A held result stays unchanged while `out_ready` is low.
- R2: A halfword with upper nibble 0xE is a conditional branch. Bits 11:8 select the test, with flags packed as {N,Z,V,C}. The codes in order are: 0 always, 1 never, 2 Z, 3 not Z, 4 C, 5 not C, 6 N, 7 not N, 8 V, 9 not V, 10 N^V, 11 not N^V, 12 (N^V)|Z, 13 not that, 14 C|Z, 15 not that.
- R3: A taken branch goes to PC+2 plus twice the sign-extended bits 7:0. A branch that is not taken goes to PC+2.
- R4: `out_extra_cycle` is 1 for a taken branch, including code 0, and 0 for a branch that is not taken, including code 1.
- R5: A halfword whose bits 15:11 are 11010 is a relative call. It goes to PC+2 plus twice the sign-extended bits 10:0, sets `out_rp_we` with `out_rp_wdata` = PC+2, and sets `out_extra_cycle`.
- R6: Upper byte 0x97 with bits 7:4 = 1 is a register call. It goes to `in_gpr`, writes PC+2 to the return pointer, and sets `out_extra_cycle`.
- R7: Upper byte 0x97 with bits 7:4 = 0 jumps to `in_gpr`. With bits 7:4 = 2 it returns to `in_rp`. Both set `out_extra_cycle` and leave `out_rp_we` low.
- R8: Every other halfword, including 0x97 with bits 7:4 of 3 or more, gives PC+2, `out_rp_we` = 0 and `out_extra_cycle` = 0.
- R9: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle if valid |
| in_instr | input | 16 | Instruction halfword |
| in_pc | input | 32 | Address of the instruction |
| in_flags | input | 4 | Flags {N,Z,V,C} |
| in_gpr | input | 32 | Value of the register named in bits 3:0 |
| in_rp | input | 32 | Current return pointer |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 32 | Next program counter |
| out_rp_we | output | 1 | Return pointer write enable |
| out_rp_wdata | output | 32 | Value for the return pointer |
| out_extra_cycle | output | 1 | Transfer takes two cycles |

## Verification
The bench uses the default parameters: a 32-bit address and a 16-bit instruction word. These give an 8-bit branch offset and an 11-bit call offset. With those widths, the exhaustive sweep of all sixteen condition codes against all sixteen flag patterns is small. The extreme displacements (+254/-256 bytes for branches, +2046/-2048 for calls) are reachable and are driven directly, along with a PC near the top of the address space. Random stall patterns on both sides of the channel exercise the hold and refusal behaviour.

// File: rtl/fru_pkg.sv
package fru_pkg;

  typedef enum logic [2:0] {
    XF_NONE,
    XF_BRANCH,
    XF_CALL_REL,
    XF_CALL_REG,
    XF_JUMP_REG,
    XF_RETURN
  } xfer_kind_e;

  localparam logic [3:0] BRANCH_NIBBLE   = 4'hE;
  localparam logic [4:0] CALL_REL_PREFIX = 5'b11010;
  localparam logic [7:0] REG_FORM_BYTE   = 8'h97;
  localparam logic [3:0] SUB_JUMP        = 4'd0;
  localparam logic [3:0] SUB_CALL        = 4'd1;
  localparam logic [3:0] SUB_RETURN      = 4'd2;

  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;

endpackage

// File: rtl/fru_decode.sv
module fru_decode
  import fru_pkg::*;
#(
  parameter int ILEN = 16
) (
  input  logic [ILEN-5:0] op_hi,
  output xfer_kind_e      kind,
  output logic [3:0]      cond
);
  localparam int HI_W = ILEN - 4;

  logic [7:0] top_byte;
  logic [3:0] sub_op;

  assign top_byte = op_hi[HI_W-1 -: 8];
  assign sub_op   = op_hi[3:0];
  assign cond     = op_hi[HI_W-5 -: 4];

  always_comb begin
    kind = XF_NONE;
    if (top_byte[7:4] == BRANCH_NIBBLE) begin
      kind = XF_BRANCH;
    end else if (top_byte[7:3] == CALL_REL_PREFIX) begin
      kind = XF_CALL_REL;
    end else if (top_byte == REG_FORM_BYTE) begin
      case (sub_op)
        SUB_JUMP:   kind = XF_JUMP_REG;
        SUB_CALL:   kind = XF_CALL_REG;
        SUB_RETURN: kind = XF_RETURN;
        default:    kind = XF_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fru_cond_eval.sv
module fru_cond_eval
  import fru_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [3:0] cond,
  output logic       pass
);
  localparam int NUM_PAIRS = 8;

  logic n, z, v, c;
  logic [NUM_PAIRS-1:0] base;
  logic [2*NUM_PAIRS-1:0] table_q;

  assign n = flags[FLAG_N];
  assign z = flags[FLAG_Z];
  assign v = flags[FLAG_V];
  assign c = flags[FLAG_C];

  // Even codes test a base expression, odd codes its complement.
  assign base[0] = 1'b1;
  assign base[1] = z;
  assign base[2] = c;
  assign base[3] = n;
  assign base[4] = v;
  assign base[5] = n ^ v;
  assign base[6] = (n ^ v) | z;
  assign base[7] = c | z;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign table_q[2*p]   = base[p];
    assign table_q[2*p+1] = ~base[p];
  end

  assign pass = table_q[cond];
endmodule

// File: rtl/fru_target_gen.sv
module fru_target_gen #(
  parameter int XLEN   = 32,
  parameter int BR_W   = 8,
  parameter int CALL_W = 11
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [BR_W-1:0]   br_off,
  input  logic [CALL_W-1:0] call_off,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   call_pc
);
  localparam int BR_EXT   = XLEN - BR_W - 1;
  localparam int CALL_EXT = XLEN - CALL_W - 1;

  logic [XLEN-1:0] br_disp, call_disp;

  assign br_disp   = {{BR_EXT{br_off[BR_W-1]}}, br_off, 1'b0};
  assign call_disp = {{CALL_EXT{call_off[CALL_W-1]}}, call_off, 1'b0};

  assign seq_pc  = pc + XLEN'(2);
  assign br_pc   = seq_pc + br_disp;
  assign call_pc = seq_pc + call_disp;
endmodule

// File: rtl/flow_redirect_unit.sv
module flow_redirect_unit
  import fru_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ILEN-1:0] in_instr,
  input  logic [XLEN-1:0] in_pc,
  input  logic [3:0]      in_flags,
  input  logic [XLEN-1:0] in_gpr,
  input  logic [XLEN-1:0] in_rp,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_rp_we,
  output logic [XLEN-1:0] out_rp_wdata,
  output logic            out_extra_cycle
);
  localparam int BR_OFF_W   = ILEN / 2;
  localparam int CALL_OFF_W = ILEN - 5;

  xfer_kind_e      kind;
  logic [3:0]      cond;
  logic            cond_ok;
  logic [XLEN-1:0] seq_pc, br_pc, call_pc;
  logic [XLEN-1:0] nxt_pc;
  logic            nxt_we, nxt_extra;
  logic            accept;

  fru_decode #(.ILEN(ILEN)) u_dec (
    .op_hi (in_instr[ILEN-1:4]),
    .kind  (kind),
    .cond  (cond)
  );

  fru_cond_eval u_cond (
    .flags (in_flags),
    .cond  (cond),
    .pass  (cond_ok)
  );

  fru_target_gen #(
    .XLEN   (XLEN),
    .BR_W   (BR_OFF_W),
    .CALL_W (CALL_OFF_W)
  ) u_tgt (
    .pc       (in_pc),
    .br_off   (in_instr[BR_OFF_W-1:0]),
    .call_off (in_instr[CALL_OFF_W-1:0]),
    .seq_pc   (seq_pc),
    .br_pc    (br_pc),
    .call_pc  (call_pc)
  );

  always_comb begin
    nxt_pc    = seq_pc;
    nxt_we    = 1'b0;
    nxt_extra = 1'b0;
    case (kind)
      XF_BRANCH: begin
        if (cond_ok) begin
          nxt_pc    = br_pc;
          nxt_extra = 1'b1;
        end
      end
      XF_CALL_REL: begin
        nxt_pc    = call_pc;
        nxt_we    = 1'b1;
        nxt_extra = 1'b1;
      end
      XF_CALL_REG: begin
        nxt_pc    = in_gpr;
        nxt_we    = 1'b1;
        nxt_extra = 1'b1;
      end
      XF_JUMP_REG: begin
        nxt_pc    = in_gpr;
        nxt_extra = 1'b1;
      end
      XF_RETURN: begin
        nxt_pc    = in_rp;
        nxt_extra = 1'b1;
      end
      default: ;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_next_pc     <= '0;
      out_rp_we       <= 1'b0;
      out_rp_wdata    <= '0;
      out_extra_cycle <= 1'b0;
    end else if (accept) begin
      out_next_pc     <= nxt_pc;
      out_rp_we       <= nxt_we;
      out_rp_wdata    <= seq_pc;
      out_extra_cycle <= nxt_extra;
    end
  end
endmodule

// File: rtl/fru_checker.sv
module fru_checker #(
  parameter int XLEN = 32,
  parameter int ILEN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [ILEN-1:0] in_instr,
  input logic [XLEN-1:0] in_pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_rp_we,
  input logic [XLEN-1:0] out_rp_wdata,
  input logic            out_extra_cycle
);
  logic take;
  assign take = in_valid & in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R9

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc)
      && $stable(out_rp_we) && $stable(out_extra_cycle)); // R1

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[15:8] == 8'hE0 |=> out_extra_cycle); // R4

  AST_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[15:8] == 8'hE1 |=>
      !out_extra_cycle && out_next_pc == $past(in_pc) + XLEN'(2)); // R4

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[15:11] == 5'b11010 |=>
      out_rp_we && out_rp_wdata == $past(in_pc) + XLEN'(2)); // R5

  AST_LINK_COSTS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rp_we |-> out_extra_cycle); // R6

  AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[15:12] < 4'h9 |=>
      !out_extra_cycle && !out_rp_we && out_next_pc == $past(in_pc) + XLEN'(2)); // R8
endmodule

bind flow_redirect_unit fru_checker #(.XLEN(XLEN), .ILEN(ILEN)) u_fru_checker (.*);

// File: tb/flow_redirect_unit_bench.sv
module flow_redirect_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [15:0] in_instr;
  logic [31:0] in_pc, in_gpr, in_rp;
  logic [3:0]  in_flags;
  logic        out_valid, out_ready;
  logic [31:0] out_next_pc, out_rp_wdata;
  logic        out_rp_we, out_extra_cycle;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flow_redirect_unit u_flow_redirect_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .in_pc(in_pc), .in_flags(in_flags), .in_gpr(in_gpr), .in_rp(in_rp),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_rp_we(out_rp_we), .out_rp_wdata(out_rp_wdata),
    .out_extra_cycle(out_extra_cycle)
  );

  typedef struct packed {
    logic [15:0] instr;
    logic [31:0] pc;
    logic [3:0]  flags;
    logic [31:0] gpr;
    logic [31:0] rp;
  } stim_t;

  stim_t stim_q[$];

  // Model state: what the output register should hold.
  bit          m_valid;
  logic [31:0] m_npc, m_wd;
  bit          m_we, m_ex;
  string       m_tag_pc, m_tag_cyc;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit cond_holds(input int code, input logic [3:0] f);
    bit n = f[3], z = f[2], v = f[1], c = f[0];
    case (code)
      0: return 1'b1;        1: return 1'b0;
      2: return z;           3: return !z;
      4: return c;           5: return !c;
      6: return n;           7: return !n;
      8: return v;           9: return !v;
      10: return n ^ v;      11: return !(n ^ v);
      12: return (n ^ v) | z; 13: return !((n ^ v) | z);
      14: return c | z;      default: return !(c | z);
    endcase
  endfunction

  task automatic predict(input stim_t s);
    int off;
    logic [31:0] nxt = s.pc + 32'd2;
    m_npc = nxt; m_wd = nxt; m_we = 0; m_ex = 0;
    m_tag_pc = "R8"; m_tag_cyc = "R8";
    if (s.instr[15:12] == 4'hE) begin
      m_tag_cyc = "R4";
      if (cond_holds(int'(s.instr[11:8]), s.flags)) begin
        off = int'(s.instr[7:0]);
        if (off >= 128) off -= 256;
        m_npc = nxt + 32'(2 * off);
        m_ex = 1; m_tag_pc = "R3";
      end else begin
        m_tag_pc = "R2";
      end
    end else if (s.instr[15:11] == 5'b11010) begin
      off = int'(s.instr[10:0]);
      if (off >= 1024) off -= 2048;
      m_npc = nxt + 32'(2 * off);
      m_we = 1; m_ex = 1; m_tag_pc = "R5"; m_tag_cyc = "R5";
    end else if (s.instr[15:8] == 8'h97 && s.instr[7:4] == 4'd1) begin
      m_npc = s.gpr; m_we = 1; m_ex = 1; m_tag_pc = "R6"; m_tag_cyc = "R6";
    end else if (s.instr[15:8] == 8'h97 && s.instr[7:4] == 4'd0) begin
      m_npc = s.gpr; m_ex = 1; m_tag_pc = "R7"; m_tag_cyc = "R7";
    end else if (s.instr[15:8] == 8'h97 && s.instr[7:4] == 4'd2) begin
      m_npc = s.rp; m_ex = 1; m_tag_pc = "R7"; m_tag_cyc = "R7";
    end
  endtask

  function automatic stim_t mk(input logic [15:0] instr, input logic [3:0] f);
    stim_t s;
    s.instr = instr;
    s.pc    = {$urandom, 1'b0} & 32'hFFFF_FFFE;
    s.flags = f;
    s.gpr   = $urandom;
    s.rp    = $urandom;
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    stim_t cur, s;
    bit drop;
    logic [15:0] r;
    rst_n = 1'b0; in_valid = 0; out_ready = 0;
    in_instr = '0; in_pc = '0; in_flags = '0; in_gpr = '0; in_rp = '0;

    // R2 sweep: every condition against every flag pattern, R3 extremes.
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        r = {4'hE, 4'(cc), 8'($urandom)};
        if (f == 0) r[7:0] = 8'h7F;
        if (f == 1) r[7:0] = 8'h80;
        stim_q.push_back(mk(r, 4'(f)));
      end
    // R5 relative calls with extreme and random offsets.
    stim_q.push_back(mk({5'b11010, 11'h3FF}, 4'h0));
    stim_q.push_back(mk({5'b11010, 11'h400}, 4'hF));
    stim_q.push_back(mk({5'b11010, 11'h000}, 4'h5));
    for (int i = 0; i < 6; i++) stim_q.push_back(mk({5'b11010, 11'($urandom)}, 4'($urandom)));
    // R6 R7 register forms, plus unused sub-operations (R8).
    for (int sub = 0; sub < 16; sub++)
      for (int i = 0; i < 3; i++)
        stim_q.push_back(mk({8'h97, 4'(sub), 4'($urandom)}, 4'($urandom)));
    // R8 other halfwords.
    for (int i = 0; i < 40; i++) begin
      do r = 16'($urandom);
      while (r[15:12] == 4'hE || r[15:11] == 5'b11010 || r[15:8] == 8'h97);
      stim_q.push_back(mk(r, 4'($urandom)));
    end
    // Address wrap at top of space.
    s = mk(16'hE07F, 4'h0); s.pc = 32'hFFFF_FFFE; stim_q.push_back(s);
    s = mk(16'hD3FF, 4'h0); s.pc = 32'hFFFF_FFF0; stim_q.push_back(s);

    // R9: reset state.
    repeat (3) begin
      @(negedge clk);
      chk("R9", "out_valid in reset", 32'(out_valid), 32'd0);
    end
    rst_n = 1'b1;
    m_valid = 0; drop = 0; cur = '0;

    while (stim_q.size() > 0 || in_valid || m_valid) begin
      @(negedge clk);
      chk("R1", "out_valid", 32'(out_valid), 32'(m_valid));
      if (m_valid && out_valid) begin
        chk(m_tag_pc, "next_pc", out_next_pc, m_npc);
        chk(m_tag_cyc, "extra_cycle", 32'(out_extra_cycle), 32'(m_ex));
        chk(m_we ? "R5" : m_tag_pc, "rp_we", 32'(out_rp_we), 32'(m_we));
        if (m_we) chk("R5", "rp_wdata", out_rp_wdata, m_wd);
      end
      if (drop) begin in_valid = 0; drop = 0; end
      out_ready = ($urandom % 4) != 0;
      if (!in_valid && stim_q.size() > 0 && ($urandom % 5) != 0) begin
        cur = stim_q.pop_front();
        in_instr = cur.instr; in_pc = cur.pc; in_flags = cur.flags;
        in_gpr = cur.gpr; in_rp = cur.rp;
        in_valid = 1;
      end
      #1;
      chk("R1", "in_ready", 32'(in_ready), 32'(!m_valid || out_ready));
      if (m_valid && out_ready) m_valid = 0;
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid = 1;
        predict(cur);
        drop = 1;
      end
    end
    @(negedge clk);
    chk("R1", "drained", 32'(out_valid), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule